// File: doc/BRIEF.md
# Layer Time-over-Threshold Meter with Event Queue

This block measures how long the OR of all discriminator outputs of one detector layer stays high, and turns that span into a coarse count. A 2-bit prescaler divides the system clock by four, so one count is worth four clock cycles (200 ns at a 20 MHz clock). The count stops at 250, which is about 50 microseconds. It is captured either when the OR goes low or when the limit is reached, whichever happens first.

Each trigger acknowledge opens one entry in a four-deep in-order queue, so every measured value stays with its own event. An entry is complete at once when the trigger arrives with no measurement in progress. If a measurement is still running, the entry is filled when that measurement ends. A trigger in the same cycle as the end of a measurement is handled explicitly: it receives the value that ends in that cycle. Results leave through a valid/ready port. `tot_valid` is high only while the oldest entry holds a final value. A result is consumed on a cycle where `tot_valid` and `tot_ready` are both high. The reader may hold `tot_ready` low for as long as it likes, and `tot_data` stays frozen while it does.

Top module: `tot_event_tracker`

## Requirements
- R1: The OR input passes through one synchronizing register. If the synchronized OR is high for N consecutive cycles, the stored value is floor(N/4), and every rising edge starts a fresh measurement from zero.
- R2: Each cycle with `trig` high adds exactly one entry while fewer than four are stored. Entries leave in the order of their triggers.
- R3: The count saturates at 250. It is captured after 1000 high cycles while the OR is still high, and the OR must then go low before a new measurement can start.
- R4: A trigger that arrives while a measurement is running creates a pending entry. `tot_valid` stays low for that entry, and for every entry behind it, until the measurement ends.
- R5: A trigger in the cycle where the measurement ends receives that measurement's value. This is the first cycle in which the synchronized OR is low. Every earlier pending entry receives the same value, and none is lost or stalled. A trigger one cycle later receives 0.
- R6: A trigger with no measurement in progress receives 0 immediately. A trigger after saturation while the OR is still high receives 250 immediately.
- R7: When `tot_en` is low at the time a value is written into an entry, the stored value is 0. Entry creation and ordering are unaffected.
- R8: A trigger while four entries are stored is dropped and sets `ovf_err`, which stays high until reset. The four stored results are left unchanged.
- R9: While `tot_valid` is high and `tot_ready` is low, `tot_valid` stays high and `tot_data` is stable. The head entry is removed only on a cycle with both high.
- R10: After reset the queue is empty, `tot_valid` is low and `ovf_err` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock (20 MHz) |
| rst_n | input | 1 | Active-low synchronous reset |
| layer_or | input | 1 | OR of the layer's discriminator outputs |
| trig | input | 1 | Trigger acknowledge, one entry per high cycle |
| tot_en | input | 1 | Measurement enable; low stores zeros |
| tot_ready | input | 1 | Reader accepts the head result |
| tot_valid | output | 1 | Head result is final |
| tot_data | output | 8 | Time-over-threshold count of the head event |
| ovf_err | output | 1 | Sticky flag: a trigger found the queue full |

## Verification
The hardest case to reach from the ports is a trigger in exactly the cycle where a running measurement closes. The bench reaches it by driving the OR low at a falling clock edge and raising `trig` at the next falling edge. This lines the trigger up with the first cycle in which the registered OR reads low. An earlier trigger in the same pulse is already pending at that moment, so both entries are filled in that one cycle. The same sequence is then shifted by one cycle to show that the late trigger gets zero. Saturation with the OR still high is reached by holding one pulse for more than 1000 cycles, with one trigger before the limit and one after it.

// File: rtl/tot_pkg.sv
package tot_pkg;
  typedef enum logic [1:0] {
    MS_IDLE  = 2'd0,
    MS_COUNT = 2'd1,
    MS_HELD  = 2'd2
  } meas_state_e;
endpackage

// File: rtl/tot_meter.sv
module tot_meter
  import tot_pkg::*;
#(
  parameter int CNT_W   = 8,
  parameter int TOT_MAX = 250,
  parameter int PRESC   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             layer_or,
  input  logic             trig,
  input  logic             tot_en,
  output logic             fill_en,
  output logic [CNT_W-1:0] fill_val,
  output logic             push_pend,
  output logic [CNT_W-1:0] push_val
);
  localparam int PRE_W = $clog2(PRESC);
  localparam logic [CNT_W-1:0] MAXV  = CNT_W'(TOT_MAX);
  localparam logic [PRE_W-1:0] PLAST = PRE_W'(PRESC - 1);

  meas_state_e      state_q;
  logic             or_s;
  logic [PRE_W-1:0] pre_q;
  logic [CNT_W-1:0] cnt_q;
  logic             sat_hit, fin, active;
  logic [CNT_W-1:0] fin_raw, push_raw;

  always_comb begin
    sat_hit  = (state_q == MS_COUNT) && or_s && (pre_q == PLAST) && (cnt_q == MAXV - 1'b1);
    fin      = (state_q == MS_COUNT) && (!or_s || sat_hit);
    fin_raw  = sat_hit ? MAXV : cnt_q;
    active   = ((state_q == MS_COUNT) && !fin) || ((state_q == MS_IDLE) && or_s);
    if (fin)                    push_raw = fin_raw;
    else if (state_q == MS_HELD) push_raw = MAXV;
    else                        push_raw = '0;
    fill_en   = fin;
    fill_val  = tot_en ? fin_raw : '0;
    push_pend = active;
    push_val  = (tot_en && !active) ? push_raw : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      or_s    <= 1'b0;
      state_q <= MS_IDLE;
      pre_q   <= '0;
      cnt_q   <= '0;
    end else begin
      or_s <= layer_or;
      unique case (state_q)
        MS_IDLE: if (or_s) begin
          state_q <= MS_COUNT;
          pre_q   <= PRE_W'(1);
          cnt_q   <= '0;
        end
        MS_COUNT: begin
          if (!or_s)       state_q <= MS_IDLE;
          else if (sat_hit) state_q <= MS_HELD;
          else begin
            pre_q <= (pre_q == PLAST) ? '0 : pre_q + 1'b1;
            if (pre_q == PLAST) cnt_q <= cnt_q + 1'b1;
          end
        end
        MS_HELD: if (!or_s) state_q <= MS_IDLE;
        default: state_q <= MS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tot_event_queue.sv
module tot_event_queue #(
  parameter int CNT_W = 8,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             push_pend,
  input  logic [CNT_W-1:0] push_val,
  input  logic             fill_en,
  input  logic [CNT_W-1:0] fill_val,
  input  logic             pop_ready,
  output logic             out_valid,
  output logic [CNT_W-1:0] out_data,
  output logic             ovf_err,
  output logic [$clog2(DEPTH):0] occ
);
  localparam int PTR_W = $clog2(DEPTH);

  logic [CNT_W-1:0] val_q [DEPTH];
  logic [DEPTH-1:0] pend_q;
  logic [PTR_W-1:0] head_q, tail;
  logic [PTR_W:0]   cnt_q;
  logic             full, push_ok, pop;

  always_comb begin
    full      = (cnt_q == (PTR_W+1)'(DEPTH));
    push_ok   = push && !full;
    tail      = head_q + cnt_q[PTR_W-1:0];
    out_valid = (cnt_q != '0) && !pend_q[head_q];
    out_data  = val_q[head_q];
    pop       = out_valid && pop_ready;
    occ       = cnt_q;
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pend_q[i] <= 1'b0;
        val_q[i]  <= '0;
      end else if (push_ok && (tail == PTR_W'(i))) begin
        pend_q[i] <= push_pend;
        val_q[i]  <= push_val;
      end else if (fill_en && pend_q[i]) begin
        pend_q[i] <= 1'b0;
        val_q[i]  <= fill_val;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q  <= '0;
      cnt_q   <= '0;
      ovf_err <= 1'b0;
    end else begin
      if (pop) head_q <= head_q + 1'b1;
      case ({push_ok, pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
      if (push && full) ovf_err <= 1'b1;
    end
  end
endmodule

// File: rtl/tot_event_tracker.sv
module tot_event_tracker #(
  parameter int CNT_W   = 8,
  parameter int TOT_MAX = 250,
  parameter int PRESC   = 4,
  parameter int DEPTH   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             layer_or,
  input  logic             trig,
  input  logic             tot_en,
  input  logic             tot_ready,
  output logic             tot_valid,
  output logic [CNT_W-1:0] tot_data,
  output logic             ovf_err
);
  localparam int OCC_W = $clog2(DEPTH) + 1;

  logic             fill_en, push_pend;
  logic [CNT_W-1:0] fill_val, push_val;
  logic [OCC_W-1:0] occ;

  tot_meter #(.CNT_W(CNT_W), .TOT_MAX(TOT_MAX), .PRESC(PRESC)) u_meter (
    .clk(clk), .rst_n(rst_n), .layer_or(layer_or), .trig(trig), .tot_en(tot_en),
    .fill_en(fill_en), .fill_val(fill_val), .push_pend(push_pend), .push_val(push_val)
  );

  tot_event_queue #(.CNT_W(CNT_W), .DEPTH(DEPTH)) u_queue (
    .clk(clk), .rst_n(rst_n), .push(trig), .push_pend(push_pend), .push_val(push_val),
    .fill_en(fill_en), .fill_val(fill_val), .pop_ready(tot_ready),
    .out_valid(tot_valid), .out_data(tot_data), .ovf_err(ovf_err), .occ(occ)
  );
endmodule

// File: rtl/tot_event_tracker_chk.sv
module tot_event_tracker_chk #(
  parameter int CNT_W   = 8,
  parameter int TOT_MAX = 250,
  parameter int DEPTH   = 4
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     trig,
  input logic                     tot_ready,
  input logic                     tot_valid,
  input logic [CNT_W-1:0]         tot_data,
  input logic                     ovf_err,
  input logic [$clog2(DEPTH):0]   occ
);
  localparam int OCC_W = $clog2(DEPTH) + 1;

  AST_TOT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    tot_valid |-> (tot_data <= CNT_W'(TOT_MAX))); // R3
  AST_HOLD_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (tot_valid && !tot_ready) |=> (tot_valid && $stable(tot_data))); // R9
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_err |=> ovf_err); // R8
  AST_FULL_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && (occ == OCC_W'(DEPTH))) |=> ovf_err); // R8
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= OCC_W'(DEPTH)); // R8
  AST_PUSH_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && (occ < OCC_W'(DEPTH)) && !(tot_valid && tot_ready)) |=> (occ == $past(occ) + 1'b1)); // R2
endmodule

bind tot_event_tracker tot_event_tracker_chk #(.CNT_W(CNT_W), .TOT_MAX(TOT_MAX), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .trig(trig), .tot_ready(tot_ready), .tot_valid(tot_valid),
  .tot_data(tot_data), .ovf_err(ovf_err), .occ(occ)
);

// File: tb/tot_event_tracker_bench.sv
module tot_event_tracker_bench;
  localparam int CLK_PERIOD = 50;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       layer_or = 1'b0;
  logic       trig = 1'b0;
  logic       tot_en = 1'b1;
  logic       tot_ready = 1'b0;
  logic       tot_valid;
  logic [7:0] tot_data;
  logic       ovf_err;

  int  n_checks = 0;
  int  n_errors = 0;
  bit  done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tot_event_tracker u_tot_event_tracker (
    .clk(clk), .rst_n(rst_n), .layer_or(layer_or), .trig(trig), .tot_en(tot_en),
    .tot_ready(tot_ready), .tot_valid(tot_valid), .tot_data(tot_data), .ovf_err(ovf_err)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic pulse_trig(input int n, input int k);
    layer_or = 1'b1;
    repeat (k) @(negedge clk);
    trig = 1'b1;
    @(negedge clk);
    trig = 1'b0;
    repeat (n - k - 1) @(negedge clk);
    layer_or = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic trig_once();
    trig = 1'b1;
    @(negedge clk);
    trig = 1'b0;
  endtask

  task automatic read_exp(input int exp, input string tag);
    int w = 0;
    while (!tot_valid && w < 20) begin
      @(negedge clk);
      w++;
    end
    chk(tot_valid == 1'b1, {tag, " valid"}, int'(tot_valid), 1);
    chk(tot_data == 8'(exp), {tag, " data"}, int'(tot_data), exp);
    tot_ready = 1'b1;
    @(negedge clk);
    tot_ready = 1'b0;
  endtask

  task automatic t_reset();
    chk(tot_valid == 1'b0, "R10 valid after reset", int'(tot_valid), 0);
    chk(ovf_err == 1'b0, "R10 err after reset", int'(ovf_err), 0);
  endtask

  task automatic t_basic();
    pulse_trig(41, 10);
    pulse_trig(4, 2);
    pulse_trig(3, 2);
    read_exp(10, "R1 n=41");
    read_exp(1, "R1 n=4");
    read_exp(0, "R2 third in order n=3");
    chk(tot_valid == 1'b0, "R2 empty after three", int'(tot_valid), 0);
  endtask

  task automatic t_pending();
    layer_or = 1'b1;
    repeat (5) @(negedge clk);
    trig_once();
    repeat (14) @(negedge clk);
    chk(tot_valid == 1'b0, "R4 pending entry not valid", int'(tot_valid), 0);
    repeat (60) @(negedge clk);
    layer_or = 1'b0;
    read_exp(20, "R4 filled after end");
  endtask

  task automatic t_coincide();
    layer_or = 1'b1;
    repeat (5) @(negedge clk);
    trig_once();
    repeat (44) @(negedge clk);
    layer_or = 1'b0;
    @(negedge clk);
    trig_once();
    trig_once();
    repeat (2) @(negedge clk);
    read_exp(12, "R5 earlier pending");
    read_exp(12, "R5 coincident trigger");
    read_exp(0, "R5 trigger one cycle late");
    chk(tot_valid == 1'b0, "R5 nothing extra queued", int'(tot_valid), 0);
  endtask

  task automatic t_idle_held();
    repeat (3) @(negedge clk);
    trig_once();
    read_exp(0, "R6 trigger without activity");
    layer_or = 1'b1;
    repeat (500) @(negedge clk);
    trig_once();
    repeat (509) @(negedge clk);
    chk(tot_valid == 1'b1, "R3 captured while OR high", int'(tot_valid), 1);
    chk(tot_data == 8'd250, "R3 saturated value", int'(tot_data), 250);
    repeat (39) @(negedge clk);
    trig_once();
    repeat (49) @(negedge clk);
    layer_or = 1'b0;
    repeat (3) @(negedge clk);
    read_exp(250, "R3 saturated entry");
    read_exp(250, "R6 trigger after saturation");
  endtask

  task automatic t_enable();
    tot_en = 1'b0;
    pulse_trig(40, 6);
    repeat (2) @(negedge clk);
    tot_en = 1'b1;
    pulse_trig(40, 6);
    read_exp(0, "R7 disabled value zero");
    read_exp(10, "R7 alignment after enable");
  endtask

  task automatic t_hold();
    pulse_trig(20, 4);
    @(negedge clk);
    chk(tot_valid == 1'b1 && tot_data == 8'd5, "R9 offered", int'(tot_data), 5);
    repeat (3) @(negedge clk);
    chk(tot_valid == 1'b1 && tot_data == 8'd5, "R9 held without ready", int'(tot_data), 5);
    read_exp(5, "R9 consumed");
    chk(tot_valid == 1'b0, "R9 removed on handshake", int'(tot_valid), 0);
  endtask

  task automatic t_overflow();
    pulse_trig(8, 3);
    pulse_trig(12, 3);
    pulse_trig(16, 3);
    pulse_trig(20, 3);
    chk(ovf_err == 1'b0, "R8 no error at four", int'(ovf_err), 0);
    trig_once();
    @(negedge clk);
    chk(ovf_err == 1'b1, "R8 error on fifth", int'(ovf_err), 1);
    read_exp(2, "R8 oldest kept 1");
    read_exp(3, "R8 kept 2");
    read_exp(4, "R8 kept 3");
    read_exp(5, "R8 kept 4");
    chk(tot_valid == 1'b0, "R8 fifth dropped", int'(tot_valid), 0);
    chk(ovf_err == 1'b1, "R8 error sticky", int'(ovf_err), 1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_pending();
    t_coincide();
    t_idle_held();
    t_enable();
    t_hold();
    t_overflow();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end
endmodule